// File: doc/BRIEF.md
# Packed SIMD Signed Lane Adder

This unit adds two 32-bit words lane by lane. A run-time width select treats each word as either two signed 16-bit halfwords or four signed 8-bit bytes. Each lane result goes to the same bit positions as the operand lanes it came from.

A second control picks the arithmetic. Plain addition keeps the low lane bits and wraps. Halving addition forms the full-precision lane sum, one bit wider than the lane, and shifts it arithmetically right by one, so a halving result can never overflow. No carry ever passes from one lane into the next.

The operation completes one cycle after it is issued. A condition-pass input can cancel the write: the result register then keeps its value and the write-enable stays low. The unit has no flag outputs and changes no status state.

Top module: `simd_lane_adder`

## Requirements
- R1: With `lane16`=1 and `halve`=0, result bits [15:0] are (op_a[15:0]+op_b[15:0]) mod 2^16 and bits [31:16] are (op_a[31:16]+op_b[31:16]) mod 2^16, with no saturation.
- R2: With `lane16`=0 and `halve`=0, each byte k (bits 8k+7:8k, k=0..3) of the result is (op_a byte k + op_b byte k) mod 256, with no saturation.
- R3: No carry crosses a lane boundary. In byte mode the boundaries are bits 8, 16 and 24. In halfword mode the only boundary is bit 16. For example, 0x00FF00FF+0x00010001 in byte mode gives 0x00000000.
- R4: With `halve`=1, each lane of width N gives bits N:1 of the (N+1)-bit sum of the sign-extended lanes. The result never overflows: 0x7F+0x7F gives 0x7F, and 0x80+0x80 gives 0x80.
- R5: `result` and `wr_en` are registered. They reflect the inputs sampled at the clock edge where `in_valid`=1, and are visible after that edge and not before it.
- R6: If `in_valid`=0 or `cond_pass`=0 at an edge, `wr_en` is 0 after that edge and `result` keeps its previous value.
- R7: While `rst_n` is low at a clock edge, `result` becomes 0 and `wr_en` becomes 0.
- R8: The halving shift rounds toward minus infinity. In byte mode, 0xFF+0x00 gives 0xFF (floor of -0.5), and 0x01+0x00 gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand |
| lane16 | input | 1 | 1 = two halfword lanes, 0 = four byte lanes |
| halve | input | 1 | 1 = halving add, 0 = wrapping add |
| cond_pass | input | 1 | Condition result; 0 cancels the write |
| in_valid | input | 1 | Operation issued this cycle |
| result | output | 32 | Registered packed result |
| wr_en | output | 1 | Registered write-enable for the result |

## Verification
The assertions assume that `lane16`, `halve` and both operands are sampled at the same edge as `in_valid`. They also assume that every input carries a known 0/1 value at each edge, and that reset is held for at least one edge before checking starts. The bench keeps within this by driving every input only on the falling edge with defined values. Reset is held for several cycles, and the mode controls change only together with the operation they belong to. The lane-isolation and sign checks are tied to the lane layout that was captured with the operation, not to the mode currently applied.

// File: rtl/simd_add_pkg.sv
// Package simd_add_pkg
// Shared constants and types for the packed lane adder.
// Assumes the word splits evenly into segments, and a wide lane is two segments.
package simd_add_pkg;
    localparam int unsigned SEG_W_DEF  = 8;
    localparam int unsigned WORD_W_DEF = 32;

    typedef enum logic {
        WIDTH_NARROW = 1'b0,
        WIDTH_WIDE   = 1'b1
    } lane_width_e;

    typedef enum logic {
        ARITH_WRAP  = 1'b0,
        ARITH_HALVE = 1'b1
    } arith_e;
endpackage

// File: rtl/simd_seg_add.sv
// Module simd_seg_add
// One segment-wide adder slice with a carry-in. It returns the low sum bits,
// the carry-out and the sign-extension bit of the signed (SEG_W+1)-bit sum.
// Assumes: purely combinational; the caller decides whether the carry-in is live.
module simd_seg_add #(
    parameter int unsigned SEG_W = 8
) (
    input  logic [SEG_W-1:0] a,
    input  logic [SEG_W-1:0] b,
    input  logic             cin,
    output logic [SEG_W-1:0] sum,
    output logic             cout,
    output logic             ext
);
    logic [SEG_W:0] full;

    // Unsigned add of the slice, one spare bit for the carry-out
    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{SEG_W{1'b0}}, cin};
        sum  = full[SEG_W-1:0];
        cout = full[SEG_W];
        ext  = a[SEG_W-1] ^ b[SEG_W-1] ^ full[SEG_W];
    end
endmodule

// File: rtl/simd_carry_ctrl.sv
// Module simd_carry_ctrl
// Decides where lanes start and stop. A segment may take the carry of the
// segment below only inside a wide lane. A segment is a lane top when its
// MSB is a lane sign bit.
// Assumes: NSEG is even; a wide lane is segments {2j+1, 2j}.
module simd_carry_ctrl #(
    parameter int unsigned NSEG = 4
) (
    input  logic            wide,
    output logic [NSEG-1:0] chain_en,
    output logic [NSEG-1:0] lane_top
);
    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        if (k % 2 == 1) begin : g_odd
            // Upper half of a wide lane: chain in when wide, always a top
            always_comb begin
                chain_en[k] = wide;
                lane_top[k] = 1'b1;
            end
        end else begin : g_even
            // Lower half or own lane: never chains in, top only in narrow mode
            always_comb begin
                chain_en[k] = 1'b0;
                lane_top[k] = ~wide;
            end
        end
    end
endmodule

// File: rtl/simd_halve_align.sv
// Module simd_halve_align
// Builds the output word from the segment sums. In wrap mode the sums pass
// straight through. In halving mode every segment shifts right by one. The
// bit shifted in is either the next segment's bit 0 (same lane) or the
// sign-extension bit of the lane sum (lane top).
// Assumes: sums and ext flags come from one consistent carry chain.
module simd_halve_align #(
    parameter int unsigned SEG_W = 8,
    parameter int unsigned NSEG  = 4
) (
    input  logic [NSEG*SEG_W-1:0] seg_sum,
    input  logic [NSEG-1:0]       seg_ext,
    input  logic [NSEG-1:0]       lane_top,
    input  logic                  halve,
    output logic [NSEG*SEG_W-1:0] word
);
    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        logic fill;
        if (k == NSEG - 1) begin : g_last
            // Highest segment is always a lane top
            always_comb fill = seg_ext[k];
        end else begin : g_mid
            // Pick lane sign or the next segment's low bit
            always_comb fill = lane_top[k] ? seg_ext[k] : seg_sum[(k+1)*SEG_W];
        end
        // Select the shifted or plain slice for this segment
        always_comb begin
            if (halve)
                word[k*SEG_W +: SEG_W] = {fill, seg_sum[k*SEG_W+1 +: SEG_W-1]};
            else
                word[k*SEG_W +: SEG_W] = seg_sum[k*SEG_W +: SEG_W];
        end
    end
endmodule

// File: rtl/simd_lane_adder.sv
// Module simd_lane_adder (top)
// Packed signed lane adder. It has narrow lanes of SEG_W bits or wide lanes of
// 2*SEG_W bits, and a wrap or halving add. The output register is written only
// when in_valid and cond_pass are both high.
// Assumes: all controls are sampled together with in_valid; synchronous
// active-low reset.
module simd_lane_adder
    import simd_add_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned SEG_W  = SEG_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              lane16,
    input  logic              halve,
    input  logic              cond_pass,
    input  logic              in_valid,
    output logic [WORD_W-1:0] result,
    output logic              wr_en
);
    localparam int unsigned NSEG = WORD_W / SEG_W;

    lane_width_e     width_sel;
    arith_e          arith_sel;
    logic [NSEG-1:0] chain_en;
    logic [NSEG-1:0] lane_top;
    logic [NSEG-1:0] seg_cin;
    logic [NSEG-1:0] seg_cout;
    logic [NSEG-1:0] seg_ext;
    logic [WORD_W-1:0] seg_sum;
    logic [WORD_W-1:0] next_word;
    logic              commit;

    // Map raw controls onto the package enums
    always_comb begin
        width_sel = lane_width_e'(lane16);
        arith_sel = arith_e'(halve);
        commit    = in_valid & cond_pass;
    end

    simd_carry_ctrl #(.NSEG(NSEG)) u_ctrl (
        .wide     (width_sel == WIDTH_WIDE),
        .chain_en (chain_en),
        .lane_top (lane_top)
    );

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        if (k == 0) begin : g_first
            // Bottom segment never receives a carry
            always_comb seg_cin[k] = 1'b0;
        end else begin : g_rest
            // Carry passes only inside a wide lane
            always_comb seg_cin[k] = chain_en[k] & seg_cout[k-1];
        end
        simd_seg_add #(.SEG_W(SEG_W)) u_add (
            .a    (op_a[k*SEG_W +: SEG_W]),
            .b    (op_b[k*SEG_W +: SEG_W]),
            .cin  (seg_cin[k]),
            .sum  (seg_sum[k*SEG_W +: SEG_W]),
            .cout (seg_cout[k]),
            .ext  (seg_ext[k])
        );
    end

    simd_halve_align #(.SEG_W(SEG_W), .NSEG(NSEG)) u_align (
        .seg_sum  (seg_sum),
        .seg_ext  (seg_ext),
        .lane_top (lane_top),
        .halve    (arith_sel == ARITH_HALVE),
        .word     (next_word)
    );

    // Output register: load on a committed operation, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            wr_en  <= 1'b0;
        end else begin
            wr_en <= commit;
            if (commit) result <= next_word;
        end
    end

    // R6
    no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid && cond_pass));

    // R5
    write_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && cond_pass)) |-> wr_en);

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid && cond_pass) |-> $stable(result));

    for (genvar k = 0; k < NSEG; k++) begin : g_chk
        // R3
        lane_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !$past(halve) && ((k % 2 == 0) || !$past(lane16)))
            |-> result[k*SEG_W] == $past(op_a[k*SEG_W] ^ op_b[k*SEG_W]));

        // R4
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && $past(halve) && ((k % 2 == 1) || !$past(lane16))
             && $past(op_a[k*SEG_W+SEG_W-1] == op_b[k*SEG_W+SEG_W-1]))
            |-> result[k*SEG_W+SEG_W-1] == $past(op_a[k*SEG_W+SEG_W-1]));
    end
endmodule

// File: tb/simd_lane_adder_bench.sv
module simd_lane_adder_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] op_a, op_b;
    logic        lane16, halve, cond_pass, in_valid;
    logic [31:0] result;
    logic        wr_en;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] exp_res = '0;

    always #5 clk = ~clk;

    simd_lane_adder u_simd_lane_adder (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .lane16(lane16), .halve(halve), .cond_pass(cond_pass),
        .in_valid(in_valid), .result(result), .wr_en(wr_en)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic l16, input logic h);
        int w = l16 ? 16 : 8;
        logic [31:0] r = '0;
        for (int i = 0; i < 32 / w; i++) begin
            int mask = (1 << w) - 1;
            int fa = int'((a >> (i * w)) & 32'(mask));
            int fb = int'((b >> (i * w)) & 32'(mask));
            int s;
            if (fa >= (1 << (w - 1))) fa = fa - (1 << w);
            if (fb >= (1 << (w - 1))) fb = fb - (1 << w);
            s = fa + fb;
            if (h) s = s >>> 1;
            r = r | (32'(s & mask) << (i * w));
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic l16, input logic h, input logic cp, input logic v);
        @(negedge clk);
        op_a = a; op_b = b; lane16 = l16; halve = h; cond_pass = cp; in_valid = v;
        @(posedge clk);
        #2;
        if (cp && v) exp_res = model(a, b, l16, h);
        check(tag, result, exp_res);
        check(tag, {31'd0, wr_en}, {31'd0, cp && v});
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] corners [8];
        logic [31:0] lfsr;
        corners = '{32'hFFFFFFFF, 32'h80008000, 32'h7FFF7FFF, 32'h80808080,
                    32'h7F7F7F7F, 32'h00FF00FF, 32'h01010101, 32'h7F80017F};
        rst_n = 1'b0; op_a = '0; op_b = '0; lane16 = 1'b0; halve = 1'b0;
        cond_pass = 1'b1; in_valid = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        // R7: reset state, even with an operation presented
        check("R7", result, 32'h0);
        check("R7", {31'd0, wr_en}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;

        // R5: the result appears only after the issuing edge
        @(negedge clk);
        op_a = 32'h01020304; op_b = 32'h10203040; lane16 = 1'b0; halve = 1'b0;
        cond_pass = 1'b1; in_valid = 1'b1;
        #1;
        check("R5", result, 32'h0);
        @(posedge clk);
        #2;
        check("R5", result, 32'h11223344);
        check("R5", {31'd0, wr_en}, 32'h1);
        exp_res = 32'h11223344;

        // R6: a cancelled or idle cycle leaves the register untouched
        do_op("R6", 32'hAAAAAAAA, 32'h55555555, 1'b1, 1'b0, 1'b0, 1'b1);
        do_op("R6", 32'h12345678, 32'h11111111, 1'b0, 1'b1, 1'b1, 1'b0);
        do_op("R6", 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0);

        // R3: carries stop at lane boundaries
        do_op("R3", 32'h00FF00FF, 32'h00010001, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R3", result, 32'h00000000);
        do_op("R3", 32'hFFFFFFFF, 32'h00010001, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R3", result, 32'h00000000);
        do_op("R3", 32'h00FF00FF, 32'h00010001, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R3", result, 32'h01000100);

        // R4: halving never overflows
        do_op("R4", 32'h7F7F8080, 32'h7F7F8080, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R4", result, 32'h7F7F8080);
        do_op("R4", 32'h7FFF8000, 32'h7FFF8000, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R4", result, 32'h7FFF8000);

        // R8: the halving shift rounds toward minus infinity
        do_op("R8", 32'hFFFF01FF, 32'h00000000, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R8", result, 32'hFFFF00FF);
        do_op("R8", 32'hFFFF0001, 32'h00000000, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R8", result, 32'hFFFF0000);

        // R2 / R4: byte sweep, every byte value of a against a spread of b
        for (int h = 0; h < 2; h++)
            for (int ia = 0; ia < 256; ia++)
                for (int ib = 0; ib < 256; ib += 8) begin
                    logic [7:0] av = 8'(ia);
                    logic [7:0] bv = 8'(ib) | (av & 8'h07);
                    do_op(h ? "R4" : "R2",
                          {av, 8'(av + 8'd85), ~av, 8'(av * 3)},
                          {bv, ~bv, 8'(bv + 8'd128), 8'(bv ^ 8'h5A)},
                          1'b0, h[0], 1'b1, 1'b1);
                end

        // R1 / R4: halfword lanes with pseudo-random operands
        lfsr = 32'hACE1_2468;
        for (int h = 0; h < 2; h++)
            for (int i = 0; i < 3000; i++) begin
                logic [31:0] a, b;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                a = lfsr;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                b = lfsr ^ {lfsr[15:0], lfsr[31:16]};
                do_op(h ? "R4" : "R1", a, b, 1'b1, h[0], 1'b1, 1'b1);
            end

        // R3: corner operand cross product in every configuration
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    do_op("R3", corners[i], corners[j], m[1], m[0], 1'b1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule